// File: doc/BRIEF.md
# Port Pin Alternate-Function Controller (Host Interrupts and DMA)

This block owns the upper half of an 8-bit quasi-bidirectional output port on a slave peripheral controller and can give four of its pins a second job. Out of reset every pin simply drives its port latch bit. A single-cycle flags-enable command turns pin 4 into a host interrupt that follows output-buffer-full status. The same command turns pin 5 into a host interrupt that signals the input buffer is empty. A single-cycle DMA-enable command turns pin 6 into a DMA request and pin 7 into an active-low DMA acknowledge input.

The port latch still matters after either enable. A 0 in latch bit 4 or 5 masks that interrupt, and a 1 in latch bit 6 raises the DMA request. The acknowledge works as a chip select: a host write while the acknowledge is low loads the host byte into the input buffer register and sets input-buffer-full. It also drops the request, so each request moves exactly one byte. Both enables stay on until reset and cannot be turned off any other way.

Top module: `hostpin_ctrl`

## Requirements
- R1: After reset all eight latch bits are 1, both alternate functions are off, `ibf` is 0, so `pin_out` reads 8'hFF.
- R2: With an alternate function off, the pins it would take (4,5 for flags; 6,7 for DMA) drive their latch bits; a latch write shows on `pin_out` one cycle after `port_wr`.
- R3: With flags enabled, `pin_out[4]` equals latch bit 4 AND `obf`, following `obf` in the same cycle.
- R4: With flags enabled, `pin_out[5]` equals latch bit 5 AND NOT `ibf`.
- R5: Writing 0 to latch bit 4 (or 5) holds that interrupt pin low whatever the status; writing 1 lets it follow the status again.
- R6: The flags and DMA functions, once enabled, stay enabled through further commands and latch writes, and only reset turns them off.
- R7: With DMA enabled, `pin_out[7]` is held at 1 (released for input), and `pin_out[6]` is the DMA request, equal to latch bit 6.
- R8: With DMA enabled, `host_wr` while `dack_n` is 0 loads `host_data` into `ibuf_data` and sets `ibf` at the next clock edge, without `host_cs`.
- R9: With DMA enabled, an active `dack_n` clears latch bit 6 at the next edge, so `pin_out[6]` falls one cycle later; this clear wins over a same-cycle latch write to bit 6.
- R10: With DMA not enabled, `dack_n` has no effect: a host write with `host_cs` low leaves `ibf` and `ibuf_data` unchanged, and latch bit 6 is kept.
- R11: `host_wr` with `host_cs` high loads the buffer and sets `ibf`; `ibf_clr` clears `ibf`; a write in the same cycle as `ibf_clr` wins and leaves `ibf` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_wr | input | 1 | Core writes the port latch |
| port_wdata | input | 8 | Value for the port latch |
| flags_en_cmd | input | 1 | One-cycle command enabling the interrupt pins |
| dma_en_cmd | input | 1 | One-cycle command enabling the DMA pins |
| obf | input | 1 | Output-buffer-full status from the host interface |
| ibf_clr | input | 1 | Core has read the input buffer; clears `ibf` |
| host_cs | input | 1 | Normal host chip select, active high |
| host_wr | input | 1 | Host write strobe, active high |
| host_data | input | 8 | Host write data |
| dack_n | input | 1 | Level sampled on pin 7, DMA acknowledge when active low |
| pin_out | output | 8 | Driven pin levels of the port |
| ibf | output | 1 | Input-buffer-full flag |
| ibuf_data | output | 8 | Input buffer register |

## Verification
The interrupt pins are combinational in `obf`, so after the bench changes `obf` on a falling edge it checks `pin_out[4]` one time step later, with no clock edge in between. Latch writes, enable commands, host writes, `ibf_clr` and the acknowledge each pass through one register. For these the bench drives on a falling edge and checks on the next falling edge, when exactly one rising edge has gone by. Pin 5 depends on `ibf`, so it is checked after that same one-edge delay.

// File: rtl/hp_pkg.sv
package hp_pkg;
    typedef struct packed {
        logic flags;
        logic dma;
    } hp_mode_t;

    localparam int unsigned HP_PORT_W = 8;
endpackage

// File: rtl/hp_mode_reg.sv
module hp_mode_reg
    import hp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flags_cmd,
    input  logic dma_cmd,
    output logic flags_on,
    output logic dma_on
);
    hp_mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (flags_cmd) mode_d.flags = 1'b1;
        if (dma_cmd)   mode_d.dma   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign flags_on = mode_q.flags;
    assign dma_on   = mode_q.dma;
endmodule

// File: rtl/hp_port_latch.sv
module hp_port_latch #(
    parameter int unsigned W       = 8,
    parameter int unsigned DRQ_BIT = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         req_clear,
    output logic [W-1:0] latch
);
    typedef struct packed {
        logic [W-1:0] bits;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr)        st_d.bits = wdata;
        if (req_clear) st_d.bits[DRQ_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.bits <= '1;
        else        st_q      <= st_d;
    end

    assign latch = st_q.bits;
endmodule

// File: rtl/hp_in_buf.sv
module hp_in_buf #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         clr,
    output logic         full,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } buf_st_t;

    buf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.full = 1'b0;
        if (load) begin
            st_d.full = 1'b1;
            st_d.data = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full = st_q.full;
    assign dout = st_q.data;
endmodule

// File: rtl/hp_pin_mux.sv
module hp_pin_mux #(
    parameter int unsigned W        = 8,
    parameter int unsigned OBF_BIT  = 4,
    parameter int unsigned IBE_BIT  = 5,
    parameter int unsigned DRQ_BIT  = 6,
    parameter int unsigned DACK_BIT = 7
) (
    input  logic [W-1:0] latch,
    input  logic         flags_on,
    input  logic         dma_on,
    input  logic         obf,
    input  logic         ibf,
    output logic [W-1:0] pins
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i == OBF_BIT) begin : g_obf
            assign pins[i] = flags_on ? (latch[i] & obf) : latch[i];
        end else if (i == IBE_BIT) begin : g_ibe
            assign pins[i] = flags_on ? (latch[i] & ~ibf) : latch[i];
        end else if (i == DACK_BIT) begin : g_dack
            assign pins[i] = dma_on | latch[i];
        end else begin : g_plain
            // DRQ pin shares the latch path: the request is the latch bit itself
            assign pins[i] = latch[i];
        end
    end
endmodule

// File: rtl/hostpin_ctrl.sv
module hostpin_ctrl #(
    parameter int unsigned W        = hp_pkg::HP_PORT_W,
    parameter int unsigned OBF_BIT  = 4,
    parameter int unsigned IBE_BIT  = 5,
    parameter int unsigned DRQ_BIT  = 6,
    parameter int unsigned DACK_BIT = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         port_wr,
    input  logic [W-1:0] port_wdata,
    input  logic         flags_en_cmd,
    input  logic         dma_en_cmd,
    input  logic         obf,
    input  logic         ibf_clr,
    input  logic         host_cs,
    input  logic         host_wr,
    input  logic [W-1:0] host_data,
    input  logic         dack_n,
    output logic [W-1:0] pin_out,
    output logic         ibf,
    output logic [W-1:0] ibuf_data
);
    logic         flags_on, dma_on, ack_act, buf_load;
    logic [W-1:0] latch;

    assign ack_act  = dma_on & ~dack_n;
    assign buf_load = host_wr & (host_cs | ack_act);

    hp_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags_cmd (flags_en_cmd),
        .dma_cmd   (dma_en_cmd),
        .flags_on  (flags_on),
        .dma_on    (dma_on)
    );

    hp_port_latch #(.W(W), .DRQ_BIT(DRQ_BIT)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (port_wr),
        .wdata     (port_wdata),
        .req_clear (ack_act),
        .latch     (latch)
    );

    hp_in_buf #(.W(W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (buf_load),
        .din   (host_data),
        .clr   (ibf_clr),
        .full  (ibf),
        .dout  (ibuf_data)
    );

    hp_pin_mux #(
        .W(W), .OBF_BIT(OBF_BIT), .IBE_BIT(IBE_BIT),
        .DRQ_BIT(DRQ_BIT), .DACK_BIT(DACK_BIT)
    ) u_mux (
        .latch    (latch),
        .flags_on (flags_on),
        .dma_on   (dma_on),
        .obf      (obf),
        .ibf      (ibf),
        .pins     (pin_out)
    );
endmodule

// File: rtl/hostpin_ctrl_chk.sv
module hostpin_ctrl_chk #(
    parameter int unsigned W        = 8,
    parameter int unsigned OBF_BIT  = 4,
    parameter int unsigned DRQ_BIT  = 6,
    parameter int unsigned DACK_BIT = 7
) (
    input logic         clk,
    input logic         rst_n,
    input logic         flags_on,
    input logic         dma_on,
    input logic         obf,
    input logic         ibf_clr,
    input logic         host_cs,
    input logic         host_wr,
    input logic [W-1:0] host_data,
    input logic         dack_n,
    input logic [W-1:0] pin_out,
    input logic         ibf,
    input logic [W-1:0] ibuf_data
);
    a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flags_on |=> flags_on);

    a_r6_dma_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dma_on |=> dma_on);

    a_r3_obf_low_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_on && !obf) |-> !pin_out[OBF_BIT]);

    a_r7_dack_released: assert property (@(posedge clk) disable iff (!rst_n)
        dma_on |-> pin_out[DACK_BIT]);

    a_r8_dma_load: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_on && !dack_n && host_wr) |=> (ibf && ibuf_data == $past(host_data)));

    a_r9_ack_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_on && !dack_n) |=> !pin_out[DRQ_BIT]);

    a_r10_no_stray_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_on && !host_cs && !ibf_clr) |=> ($stable(ibf) && $stable(ibuf_data)));

    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_wr && ibf_clr) |=> ibf);
endmodule

bind hostpin_ctrl hostpin_ctrl_chk #(
    .W(W), .OBF_BIT(OBF_BIT), .DRQ_BIT(DRQ_BIT), .DACK_BIT(DACK_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags_on  (flags_on),
    .dma_on    (dma_on),
    .obf       (obf),
    .ibf_clr   (ibf_clr),
    .host_cs   (host_cs),
    .host_wr   (host_wr),
    .host_data (host_data),
    .dack_n    (dack_n),
    .pin_out   (pin_out),
    .ibf       (ibf),
    .ibuf_data (ibuf_data)
);

// File: tb/hostpin_ctrl_bench.sv
`timescale 1ns/1ps
module hostpin_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_wr = 1'b0;
    logic [7:0] port_wdata = '0;
    logic       flags_en_cmd = 1'b0;
    logic       dma_en_cmd = 1'b0;
    logic       obf = 1'b1;
    logic       ibf_clr = 1'b0;
    logic       host_cs = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_data = '0;
    logic       dack_n = 1'b1;
    logic [7:0] pin_out;
    logic       ibf;
    logic [7:0] ibuf_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hostpin_ctrl u_hostpin_ctrl (
        .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
        .flags_en_cmd(flags_en_cmd), .dma_en_cmd(dma_en_cmd), .obf(obf),
        .ibf_clr(ibf_clr), .host_cs(host_cs), .host_wr(host_wr),
        .host_data(host_data), .dack_n(dack_n), .pin_out(pin_out),
        .ibf(ibf), .ibuf_data(ibuf_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one register stage: drive at a falling edge, check at the next one
    task automatic step();
        @(negedge clk);
        port_wr = 1'b0; flags_en_cmd = 1'b0; dma_en_cmd = 1'b0;
        ibf_clr = 1'b0; host_cs = 1'b0; host_wr = 1'b0;
    endtask

    task automatic latch_write(input logic [7:0] v);
        port_wr = 1'b1; port_wdata = v; step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step(); step(); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 pins", pin_out, 8'hFF);
        check("R1 ibf", {7'd0, ibf}, 8'h00);
    endtask

    task automatic t_plain();
        latch_write(8'hA5);
        check("R2 latch on pins", pin_out, 8'hA5);
        obf = 1'b0; dack_n = 1'b0; #1;
        check("R2 status ignored before enable", pin_out, 8'hA5);
        obf = 1'b1; dack_n = 1'b1;
        latch_write(8'hFF);
    endtask

    task automatic t_cs_write();
        host_cs = 1'b1; host_wr = 1'b1; host_data = 8'h3C; step();
        check("R11 cs load flag", {7'd0, ibf}, 8'h01);
        check("R11 cs load data", ibuf_data, 8'h3C);
        ibf_clr = 1'b1; step();
        check("R11 clear", {7'd0, ibf}, 8'h00);
        host_cs = 1'b1; host_wr = 1'b1; host_data = 8'h5A; ibf_clr = 1'b1; step();
        check("R11 write beats clear", {7'd0, ibf}, 8'h01);
        check("R11 write beats clear data", ibuf_data, 8'h5A);
        ibf_clr = 1'b1; step();
    endtask

    task automatic t_ignore_dack();
        dack_n = 1'b0; host_wr = 1'b1; host_data = 8'h99; step();
        check("R10 ibf unchanged", {7'd0, ibf}, 8'h00);
        check("R10 data unchanged", ibuf_data, 8'h5A);
        check("R10 request bit kept", {7'd0, pin_out[6]}, 8'h01);
        dack_n = 1'b1;
    endtask

    task automatic t_flags();
        flags_en_cmd = 1'b1; step();
        obf = 1'b0; #1;
        check("R3 obf low", {7'd0, pin_out[4]}, 8'h00);
        obf = 1'b1; #1;
        check("R3 obf high", {7'd0, pin_out[4]}, 8'h01);
        check("R4 empty raises pin5", {7'd0, pin_out[5]}, 8'h01);
        host_cs = 1'b1; host_wr = 1'b1; host_data = 8'h11; step();
        check("R4 full drops pin5", {7'd0, pin_out[5]}, 8'h00);
        ibf_clr = 1'b1; step();
        check("R4 cleared raises pin5", {7'd0, pin_out[5]}, 8'h01);
        latch_write(8'hCF);
        check("R5 masked pin4", {7'd0, pin_out[4]}, 8'h00);
        check("R5 masked pin5", {7'd0, pin_out[5]}, 8'h00);
        latch_write(8'hFF);
        check("R5 unmasked pin4", {7'd0, pin_out[4]}, 8'h01);
    endtask

    task automatic t_dma();
        dma_en_cmd = 1'b1; step();
        latch_write(8'h3F);
        check("R7 pin7 released", {7'd0, pin_out[7]}, 8'h01);
        check("R7 no request", {7'd0, pin_out[6]}, 8'h00);
        latch_write(8'hFF);
        check("R7 request up", {7'd0, pin_out[6]}, 8'h01);
        dack_n = 1'b0; host_wr = 1'b1; host_data = 8'hC3;
        port_wr = 1'b1; port_wdata = 8'hFF; step();
        dack_n = 1'b1;
        check("R8 ack load flag", {7'd0, ibf}, 8'h01);
        check("R8 ack load data", ibuf_data, 8'hC3);
        check("R9 request dropped", {7'd0, pin_out[6]}, 8'h00);
        ibf_clr = 1'b1; step();
    endtask

    task automatic t_sticky();
        flags_en_cmd = 1'b1; dma_en_cmd = 1'b1; step();
        latch_write(8'h00);
        latch_write(8'hFF);
        obf = 1'b0; #1;
        check("R6 flags still on", {7'd0, pin_out[4]}, 8'h00);
        latch_write(8'h7F);
        check("R6 dma still on", {7'd0, pin_out[7]}, 8'h01);
        do_reset();
        #1;
        check("R6 reset ends flags", {7'd0, pin_out[4]}, 8'h01);
        latch_write(8'h00);
        check("R6 reset ends dma", pin_out, 8'h00);
        obf = 1'b1;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        do_reset();
        t_reset();
        t_plain();
        t_cs_write();
        t_ignore_dack();
        t_flags();
        t_dma();
        t_sticky();
        finish_up();
    end
endmodule